// File: doc/BRIEF.md
# Converter Power-Up and Calibration Sequencer

This block controls when an on-chip analog-to-digital converter may be used. It divides the bus clock into a periodic converter clock enable. It also runs a small state machine that covers power-up, a settling wait, a reset of the calibration data and the self-calibration run. Software drives single-cycle command strobes: power on, power off, reset calibration, calibrate and start conversion. It polls the busy flags, which the hardware lowers when each operation finishes.

Calibration is accepted only when the converter has settled, no other operation is running, and the last power-up followed an off period of at least `OFF_MIN` converter clock ticks. A calibrate strobe that breaks these rules starts nothing and sets a sticky error flag instead. The calibration run and the calibration-data reset are both modelled as fixed-length busy windows. The `ready` output gates every conversion start, so no start gets through while the converter is off, settling, resetting calibration data or calibrating.

Top module: `adcpc_top`

## Requirements
- R1: `conv_tick` pulses once every 2, 4, 6 or 8 bus cycles for `div_sel` = 0, 1, 2 or 3, and is never high in two consecutive cycles.
- R2: A `pon_wr` strobe while off raises `powered` in the next cycle. `ready` rises exactly `STAB_CYC` cycles after the edge that raised `powered`.
- R3: A `pon_wr` strobe while powered has no effect: settling is not restarted and `ready` stays high.
- R4: `conv_go` is high in the same cycle as `conv_wr` only when `ready` is high. While powered off, `conv_wr` is ignored.
- R5: `rcal_wr` while ready raises `rcal_busy` for exactly `RCAL_CYC` cycles. The hardware then clears it and `ready` returns.
- R6: An accepted `cal_wr` raises `cal_busy` for exactly `CAL_CYC` cycles. The hardware then clears it and `ready` returns.
- R7: Calibration is accepted only if the converter was off for at least `OFF_MIN` converter ticks before its latest power-up. The time since reset counts as off time.
- R8: A `cal_wr` while off, while settling, or without a long enough off period starts nothing and sets `cal_err`. `cal_err` stays set until a calibration is accepted. Strobes that arrive during an operation are ignored and leave `cal_err` unchanged.
- R9: While `rcal_busy` or `cal_busy` is high, `ready` is low and `conv_wr` produces no `conv_go`.
- R10: `poff_wr` has top priority and returns the block to off in the next cycle, aborting any operation.
- R11: After reset, `powered`, `ready`, `rcal_busy`, `cal_busy`, `cal_err` and `conv_go` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Converter clock divider select (0:/2, 1:/4, 2:/6, 3:/8) |
| pon_wr | input | 1 | Power-on command strobe |
| poff_wr | input | 1 | Power-off command strobe |
| rcal_wr | input | 1 | Reset-calibration-data command strobe |
| cal_wr | input | 1 | Calibrate command strobe |
| conv_wr | input | 1 | Direct conversion start request |
| conv_tick | output | 1 | Converter clock enable |
| powered | output | 1 | Converter is powered |
| ready | output | 1 | Converter settled and idle |
| rcal_busy | output | 1 | Calibration-data reset in progress |
| cal_busy | output | 1 | Calibration in progress |
| cal_err | output | 1 | Sticky flag for a rejected calibrate request |
| conv_go | output | 1 | Accepted conversion start |

## Verification
The bench measures the tick spacing at every divider setting, after letting each change settle. It counts the exact cycle in which `ready` rises after power-up and in which each busy window closes, so a timer that is off by one shows up at once. It issues a power-on strobe while already settled; a design that restarts settling would drop `ready`. It also tries conversion starts while off and during busy windows. It power-cycles quickly at the slowest divider to provoke a rejected calibration, and checks that the error flag holds and then clears on a later calibration that is accepted. It checks that a design which ignored the off interval, or never latched the error, would be caught. It ends by aborting a running calibration with a power-off strobe.

// File: rtl/adcpc_pkg.sv
package adcpc_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_STAB,
        ST_IDLE,
        ST_RCAL,
        ST_CAL
    } seq_st_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adcpc_prescaler.sv
module adcpc_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = SEL_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        // terminal count = 2*(sel+1)-1
        lim   = {div_sel, 1'b1};
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adcpc_offmon.sv
module adcpc_offmon #(
    parameter int OFF_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_off,
    input  logic tick,
    output logic long_enough
);
    localparam int OW = $clog2(OFF_MIN + 1) + 1;

    logic [OW-1:0] cnt_d, cnt_q;

    always_comb begin
        long_enough = (cnt_q >= OW'(OFF_MIN));
        if (!is_off)
            cnt_d = '0;
        else if (tick && !long_enough)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    off_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= OW'(OFF_MIN));

endmodule

// File: rtl/adcpc_seq.sv
module adcpc_seq
    import adcpc_pkg::*;
#(
    parameter int STAB_CYC = 12,
    parameter int RCAL_CYC = 4,
    parameter int CAL_CYC  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pon_wr,
    input  logic poff_wr,
    input  logic rcal_wr,
    input  logic cal_wr,
    input  logic conv_wr,
    input  logic off_long,
    output logic is_off,
    output logic powered,
    output logic ready,
    output logic rcal_busy,
    output logic cal_busy,
    output logic cal_err,
    output logic conv_go
);
    localparam int MAXC = max3(STAB_CYC, RCAL_CYC, CAL_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [TW-1:0] tmr;
        logic          pd_ok;
        logic          err;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_OFF: begin
                if (cal_wr) s_d.err = 1'b1;
                if (pon_wr) begin
                    s_d.st    = ST_STAB;
                    s_d.tmr   = TW'(STAB_CYC - 1);
                    s_d.pd_ok = off_long;
                end
            end
            ST_STAB: begin
                if (cal_wr) s_d.err = 1'b1;
                if (s_q.tmr == '0) s_d.st  = ST_IDLE;
                else               s_d.tmr = s_q.tmr - 1'b1;
            end
            ST_IDLE: begin
                if (rcal_wr) begin
                    s_d.st  = ST_RCAL;
                    s_d.tmr = TW'(RCAL_CYC - 1);
                end else if (cal_wr) begin
                    if (s_q.pd_ok) begin
                        s_d.st  = ST_CAL;
                        s_d.tmr = TW'(CAL_CYC - 1);
                        s_d.err = 1'b0;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_RCAL, ST_CAL: begin
                if (s_q.tmr == '0) s_d.st  = ST_IDLE;
                else               s_d.tmr = s_q.tmr - 1'b1;
            end
            default: s_d.st = ST_OFF;
        endcase
        if (poff_wr) begin
            s_d.st    = ST_OFF;
            s_d.tmr   = '0;
            s_d.pd_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_OFF;
            s_q.tmr   <= '0;
            s_q.pd_ok <= 1'b0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        is_off    = (s_q.st == ST_OFF);
        powered   = !is_off;
        ready     = (s_q.st == ST_IDLE);
        rcal_busy = (s_q.st == ST_RCAL);
        cal_busy  = (s_q.st == ST_CAL);
        cal_err   = s_q.err;
        conv_go   = conv_wr && ready;
    end

    // R2
    ready_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> powered);

    // R9
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, rcal_busy, cal_busy}));

    // R4
    conv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> (powered && !rcal_busy && !cal_busy));

    // R6
    cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> ($past(cal_wr) && !$past(poff_wr)));

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_err) |-> $past(cal_wr));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poff_wr |=> !powered);

endmodule

// File: rtl/adcpc_top.sv
module adcpc_top #(
    parameter int STAB_CYC = 12,
    parameter int RCAL_CYC = 4,
    parameter int CAL_CYC  = 20,
    parameter int OFF_MIN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       pon_wr,
    input  logic       poff_wr,
    input  logic       rcal_wr,
    input  logic       cal_wr,
    input  logic       conv_wr,
    output logic       conv_tick,
    output logic       powered,
    output logic       ready,
    output logic       rcal_busy,
    output logic       cal_busy,
    output logic       cal_err,
    output logic       conv_go
);
    logic is_off;
    logic off_long;

    adcpc_prescaler #(.SEL_W(2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (conv_tick)
    );

    adcpc_offmon #(.OFF_MIN(OFF_MIN)) u_offmon (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_off      (is_off),
        .tick        (conv_tick),
        .long_enough (off_long)
    );

    adcpc_seq #(
        .STAB_CYC (STAB_CYC),
        .RCAL_CYC (RCAL_CYC),
        .CAL_CYC  (CAL_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pon_wr    (pon_wr),
        .poff_wr   (poff_wr),
        .rcal_wr   (rcal_wr),
        .cal_wr    (cal_wr),
        .conv_wr   (conv_wr),
        .off_long  (off_long),
        .is_off    (is_off),
        .powered   (powered),
        .ready     (ready),
        .rcal_busy (rcal_busy),
        .cal_busy  (cal_busy),
        .cal_err   (cal_err),
        .conv_go   (conv_go)
    );

endmodule

// File: tb/tb_adcpc_top.sv
module tb_adcpc_top;
    localparam int CLK_PER  = 10;
    localparam int STAB_CYC = 12;
    localparam int RCAL_CYC = 4;
    localparam int CAL_CYC  = 20;
    localparam int OFF_MIN  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       pon_wr = 0, poff_wr = 0, rcal_wr = 0, cal_wr = 0, conv_wr = 0;
    logic       conv_tick, powered, ready, rcal_busy, cal_busy, cal_err, conv_go;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PER/2) clk = ~clk;

    adcpc_top #(
        .STAB_CYC(STAB_CYC), .RCAL_CYC(RCAL_CYC),
        .CAL_CYC(CAL_CYC), .OFF_MIN(OFF_MIN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .pon_wr(pon_wr), .poff_wr(poff_wr), .rcal_wr(rcal_wr),
        .cal_wr(cal_wr), .conv_wr(conv_wr),
        .conv_tick(conv_tick), .powered(powered), .ready(ready),
        .rcal_busy(rcal_busy), .cal_busy(cal_busy),
        .cal_err(cal_err), .conv_go(conv_go)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a one-cycle strobe; returns at the negedge after the sampling edge
    task automatic strobe(input int which);
        case (which)
            0: pon_wr  = 1'b1;
            1: poff_wr = 1'b1;
            2: rcal_wr = 1'b1;
            default: cal_wr = 1'b1;
        endcase
        @(negedge clk);
        pon_wr = 0; poff_wr = 0; rcal_wr = 0; cal_wr = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic try_conv(input string req, input int exp);
        conv_wr = 1'b1;
        #1;
        chk(req, conv_go, exp);
        conv_wr = 1'b0;
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!conv_tick) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 powered", powered, 0);
        chk("R11 ready", ready, 0);
        chk("R11 busy", rcal_busy | cal_busy, 0);
        chk("R11 err", cal_err, 0);
        chk("R11 conv_go", conv_go, 0);
    endtask

    task automatic t_prescale();
        for (int s = 0; s < 4; s++) begin
            int gap;
            div_sel = 2'(s);
            wait_tick();
            wait_tick();
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!conv_tick);
            chk("R1 tick period", gap, 2 * (s + 1));
        end
        div_sel = 2'd0;
        wait_cyc(8);
    endtask

    task automatic t_conv_off();
        try_conv("R4 conv while off", 0);
        chk("R4 still off", powered, 0);
    endtask

    task automatic t_power_up(input string req);
        strobe(0);
        chk({req, " powered"}, powered, 1);
        chk({req, " ready early"}, ready, 0);
        wait_cyc(STAB_CYC - 1);
        chk({req, " ready one before"}, ready, 0);
        wait_cyc(1);
        chk({req, " ready at count"}, ready, 1);
    endtask

    task automatic t_pon_again();
        strobe(0);
        chk("R3 ready kept", ready, 1);
        wait_cyc(2);
        chk("R3 ready still", ready, 1);
        try_conv("R4 conv when ready", 1);
    endtask

    task automatic t_rcal();
        strobe(2);
        chk("R5 rcal_busy", rcal_busy, 1);
        chk("R9 ready low rcal", ready, 0);
        try_conv("R9 conv during rcal", 0);
        wait_cyc(RCAL_CYC - 1);
        chk("R5 busy last", rcal_busy, 1);
        wait_cyc(1);
        chk("R5 cleared", rcal_busy, 0);
        chk("R5 ready back", ready, 1);
    endtask

    task automatic t_cal_ok(input string req);
        strobe(3);
        chk({req, " cal_busy"}, cal_busy, 1);
        chk({req, " err clear"}, cal_err, 0);
        try_conv("R9 conv during cal", 0);
        wait_cyc(CAL_CYC - 1);
        chk("R6 busy last", cal_busy, 1);
        wait_cyc(1);
        chk("R6 cleared", cal_busy, 0);
        chk("R6 ready back", ready, 1);
    endtask

    task automatic t_cal_short_off();
        div_sel = 2'd3;
        strobe(1);
        chk("R10 off", powered, 0);
        t_power_up("R2 quick");
        strobe(3);
        chk("R7 cal rejected", cal_busy, 0);
        chk("R8 err set", cal_err, 1);
        chk("R8 ready kept", ready, 1);
        wait_cyc(5);
        chk("R8 err sticky", cal_err, 1);
    endtask

    task automatic t_cal_recover();
        strobe(1);
        wait_cyc(8 * (OFF_MIN + 2));
        t_power_up("R2 slow");
        chk("R8 err held", cal_err, 1);
        t_cal_ok("R8 recovery");
    endtask

    task automatic t_abort();
        strobe(3);
        chk("R6 cal started", cal_busy, 1);
        wait_cyc(3);
        strobe(1);
        chk("R10 powered", powered, 0);
        chk("R10 cal aborted", cal_busy, 0);
        chk("R10 ready", ready, 0);
        try_conv("R4 conv after abort", 0);
        strobe(3);
        chk("R8 cal while off err", cal_err, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_prescale();
        t_conv_off();
        t_power_up("R2");
        t_pon_again();
        t_rcal();
        t_cal_ok("R6 R7");
        t_cal_short_off();
        t_cal_recover();
        t_abort();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule